// File: doc/BRIEF.md
# Two-Stage Quantizer Code Merger with Saturation and Restart Gating

This block is the digital back end of a two-step subranging converter. On each rising edge of the sample clock it takes a coarse estimate, a fine code that digitizes the coarse stage's residue, and two comparator flags that mark an input beyond either end of the range. The two codes overlap by one bit. The block merges them into one 10-bit offset-binary word, in which 0x200 is mid-scale, 0x3FF is the top of the range, 0x000 is the bottom, and bit 9 is the MSB.

A flagged sample is replaced by the saturation code for its direction, and the out-of-range output goes high for that sample. The result leaves the block through a fixed pipeline and one result is produced per clock. A valid output stays low after a clock gap or an explicit flush until the pipeline holds only fresh samples.

Top module: `subrange_merge_pipe`

## Requirements
- R1: With neither flag set, the output code equals `coarse_i*32 + fine_i - 16`, where `coarse_i` is a 5-bit unsigned value and `fine_i` is a 6-bit unsigned value.
- R2: With neither flag set, a merged value below 0 gives 0x000 and a merged value above 1023 gives 0x3FF. In both cases `ovr_o` stays low.
- R3: A sample captured on rising edge N appears on `data_o` and `ovr_o` right after edge N+3. A new result appears on every edge.
- R4: When `ovr_pos_i` is set, the sample's result is 0x3FF and `ovr_o` is 1.
- R5: When `ovr_neg_i` is set alone, the sample's result is 0x000 and `ovr_o` is 1.
- R6: When both flags are set, the positive flag wins: the result is 0x3FF and `ovr_o` is 1.
- R7: `ovr_o` is high only for a flagged sample. An in-range merge that lands exactly on 0x3FF or 0x000 gives `ovr_o` low.
- R8: An edge with `idle_i` high forces `valid_o` low after that edge. `valid_o` then stays low until four consecutive edges have seen `idle_i` low with `flush_n` high.
- R9: An edge with `flush_n` low has the same effect on `valid_o` as `idle_i` high.
- R10: A synchronous active-low `rst_n` drives `data_o` to 0x200 and drives `ovr_o` and `valid_o` low. The first three results after reset release are also 0x200 with `ovr_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| coarse_i | input | 5 | Coarse quantizer estimate |
| fine_i | input | 6 | Fine quantizer residue code |
| ovr_pos_i | input | 1 | Input above range comparator |
| ovr_neg_i | input | 1 | Input below range comparator |
| idle_i | input | 1 | Clock-gap marker; clears the valid tracking |
| flush_n | input | 1 | Pipeline flush, active low |
| data_o | output | 10 | Offset-binary result |
| ovr_o | output | 1 | Out-of-range marker for the result on `data_o` |
| valid_o | output | 1 | High when `data_o` holds a fresh sample |

## Verification
The checker covers the following on every cycle:
- saturation and its priority for flagged samples, four edges later as seen from the sampled ports;
- the rule that an out-of-range output always carries a saturation code;
- the clearing of `valid_o` by idle or flush;
- the need for four good edges before `valid_o` rises;
- the mid-scale output just after reset.

The exact merge arithmetic and the clamp at both ends can only be shown by the bench's scenarios. The bench sweeps every coarse and fine pair, walks the flag combinations, and injects idle and flush events at varied spacings, comparing each result three edges after it was captured.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int COARSE_W   = 5;
  localparam int FINE_W     = 6;
  localparam int CODE_W     = 10;
  localparam int PIPE_DEPTH = 3;
  localparam int SUM_W      = CODE_W + 2;
  localparam int STEP_SHIFT = FINE_W - 1;
  localparam int OVERLAP    = 1 << (FINE_W - 2);
  localparam int VCHAIN_W   = PIPE_DEPTH + 1;

  localparam logic [CODE_W-1:0]   CODE_TOP = '1;
  localparam logic [CODE_W-1:0]   CODE_BOT = '0;
  localparam logic [CODE_W-1:0]   CODE_MID = CODE_W'(1) << (CODE_W - 1);
  localparam logic [COARSE_W-1:0] COARSE_MID = COARSE_W'(1) << (COARSE_W - 1);
  localparam logic [FINE_W-1:0]   FINE_MID = FINE_W'(OVERLAP);

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              ovr;
  } result_t;

  localparam result_t RESULT_MID = '{code: CODE_MID, ovr: 1'b0};

  // Overlap-corrected sum of the two stage codes, signed so that an
  // undershoot below zero remains visible to the clamp.
  function automatic logic signed [SUM_W-1:0] merge_sum(
    input logic [COARSE_W-1:0] coarse,
    input logic [FINE_W-1:0]   fine
  );
    logic [SUM_W-1:0] acc;
    acc = (SUM_W'(coarse) << STEP_SHIFT) + SUM_W'(fine) - SUM_W'(OVERLAP);
    return $signed(acc);
  endfunction

  // Comparator flags win over arithmetic; positive flag wins over negative.
  function automatic result_t resolve(
    input logic [COARSE_W-1:0] coarse,
    input logic [FINE_W-1:0]   fine,
    input logic                pos,
    input logic                neg
  );
    result_t r;
    logic signed [SUM_W-1:0] s;
    s = merge_sum(coarse, fine);
    if (pos) begin
      r = '{code: CODE_TOP, ovr: 1'b1};
    end else if (neg) begin
      r = '{code: CODE_BOT, ovr: 1'b1};
    end else if (s < 0) begin
      r = '{code: CODE_BOT, ovr: 1'b0};
    end else if (s > $signed(SUM_W'(CODE_TOP))) begin
      r = '{code: CODE_TOP, ovr: 1'b0};
    end else begin
      r = '{code: s[CODE_W-1:0], ovr: 1'b0};
    end
    return r;
  endfunction
endpackage

// File: rtl/srm_capture.sv
module srm_capture
  import srm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                pos_i,
  input  logic                neg_i,
  output logic [COARSE_W-1:0] coarse_q,
  output logic [FINE_W-1:0]   fine_q,
  output logic                pos_q,
  output logic                neg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_q <= COARSE_MID;
      fine_q   <= FINE_MID;
      pos_q    <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      coarse_q <= coarse_i;
      fine_q   <= fine_i;
      pos_q    <= pos_i;
      neg_q    <= neg_i;
    end
  end
endmodule

// File: rtl/srm_merge_stage.sv
module srm_merge_stage
  import srm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] coarse_q,
  input  logic [FINE_W-1:0]   fine_q,
  input  logic                pos_q,
  input  logic                neg_q,
  output result_t             res_q
);
  result_t res_d;

  always_comb res_d = resolve(coarse_q, fine_q, pos_q, neg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) res_q <= RESULT_MID;
    else        res_q <= res_d;
  end
endmodule

// File: rtl/srm_delay_line.sv
module srm_delay_line
  import srm_pkg::*;
#(
  parameter int STAGES = PIPE_DEPTH - 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  result_t din,
  output result_t dout
);
  result_t taps [STAGES+1];

  assign taps[0] = din;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) taps[g+1] <= RESULT_MID;
      else        taps[g+1] <= taps[g];
    end
  end

  assign dout = taps[STAGES];
endmodule

// File: rtl/srm_valid_chain.sv
module srm_valid_chain
  import srm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic good_edge,
  output logic valid_o
);
  logic [VCHAIN_W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !good_edge) chain_q <= '0;
    else                      chain_q <= {chain_q[VCHAIN_W-2:0], 1'b1};
  end

  assign valid_o = chain_q[VCHAIN_W-1];
endmodule

// File: rtl/subrange_merge_pipe.sv
module subrange_merge_pipe
  import srm_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  input  logic                ovr_pos_i,
  input  logic                ovr_neg_i,
  input  logic                idle_i,
  input  logic                flush_n,
  output logic [CODE_W-1:0]   data_o,
  output logic                ovr_o,
  output logic                valid_o
);
  logic [COARSE_W-1:0] cap_coarse;
  logic [FINE_W-1:0]   cap_fine;
  logic                cap_pos;
  logic                cap_neg;
  result_t             merged_q;
  result_t             out_q;
  logic                good_edge;

  // An edge counts toward refilling only when the clock is running and no
  // flush is requested.
  assign good_edge = !idle_i && flush_n;

  srm_capture cap_i (
    .clk(clk), .rst_n(rst_n),
    .coarse_i(coarse_i), .fine_i(fine_i), .pos_i(ovr_pos_i), .neg_i(ovr_neg_i),
    .coarse_q(cap_coarse), .fine_q(cap_fine), .pos_q(cap_pos), .neg_q(cap_neg)
  );

  srm_merge_stage merge_i (
    .clk(clk), .rst_n(rst_n),
    .coarse_q(cap_coarse), .fine_q(cap_fine), .pos_q(cap_pos), .neg_q(cap_neg),
    .res_q(merged_q)
  );

  srm_delay_line #(.STAGES(PIPE_DEPTH - 1)) delay_i (
    .clk(clk), .rst_n(rst_n), .din(merged_q), .dout(out_q)
  );

  srm_valid_chain vchain_i (
    .clk(clk), .rst_n(rst_n), .good_edge(good_edge), .valid_o(valid_o)
  );

  assign data_o = out_q.code;
  assign ovr_o  = out_q.ovr;
endmodule

// File: rtl/srm_checker.sv
module srm_checker
  import srm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ovr_pos_i,
  input logic              ovr_neg_i,
  input logic              good_edge,
  input logic [CODE_W-1:0] data_o,
  input logic              ovr_o,
  input logic              valid_o
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (!rst_n)                since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  // Sampled outputs show the result of the edge before, so a flag seen four
  // sampling points back belongs to the result on the ports now.
  assert_pos_sat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && $past(ovr_pos_i, 4)) |-> (data_o == CODE_TOP && ovr_o));

  assert_neg_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd4 && $past(ovr_neg_i && !ovr_pos_i, 4)) |-> (data_o == CODE_BOT && ovr_o));

  assert_ovr_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_o |-> (data_o == CODE_TOP || data_o == CODE_BOT));

  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !good_edge |=> !valid_o);

  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> ($past(good_edge, 1) && $past(good_edge, 2) &&
                        $past(good_edge, 3) && $past(good_edge, 4)));

  assert_reset_mid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= 3'd3) |-> (data_o == CODE_MID && !ovr_o && !valid_o));
endmodule

bind subrange_merge_pipe srm_checker chk_i (
  .clk(clk), .rst_n(rst_n), .ovr_pos_i(ovr_pos_i), .ovr_neg_i(ovr_neg_i),
  .good_edge(good_edge), .data_o(data_o), .ovr_o(ovr_o), .valid_o(valid_o)
);

// File: tb/subrange_merge_pipe_tb.sv
module subrange_merge_pipe_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] coarse_i;
  logic [5:0] fine_i;
  logic       ovr_pos_i, ovr_neg_i, idle_i, flush_n;
  logic [9:0] data_o;
  logic       ovr_o, valid_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  int run   = 0;
  bit done  = 1'b0;
  int    q_code [$];
  int    q_ovr  [$];
  string q_tag  [$];

  always #2 clk = ~clk;

  subrange_merge_pipe dut_i (
    .clk(clk), .rst_n(rst_n), .coarse_i(coarse_i), .fine_i(fine_i),
    .ovr_pos_i(ovr_pos_i), .ovr_neg_i(ovr_neg_i), .idle_i(idle_i),
    .flush_n(flush_n), .data_o(data_o), .ovr_o(ovr_o), .valid_o(valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // One sample per call: drive at the falling edge, check after the next
  // rising edge the result captured three edges earlier.
  task automatic step(input int c, input int f, input bit p, input bit n,
                      input bit idl, input bit fl);
    int sum, ec, eo;
    string tg;
    coarse_i = 5'(c); fine_i = 6'(f);
    ovr_pos_i = p; ovr_neg_i = n; idle_i = idl; flush_n = fl;
    sum = c * 32 + f - 16;
    if (p)             begin ec = 1023; eo = 1; tg = n ? "R6" : "R4"; end
    else if (n)        begin ec = 0;    eo = 1; tg = "R5"; end
    else if (sum < 0)  begin ec = 0;    eo = 0; tg = "R2"; end
    else if (sum > 1023) begin ec = 1023; eo = 0; tg = "R2"; end
    else               begin ec = sum;  eo = 0; tg = "R1/R3"; end
    q_code.push_back(ec); q_ovr.push_back(eo); q_tag.push_back(tg);
    run = (!idl && fl) ? run + 1 : 0;
    @(posedge clk);
    @(negedge clk);
    if (cyc >= 3) begin
      int xc, xo;
      string xt;
      xc = q_code.pop_front(); xo = q_ovr.pop_front(); xt = q_tag.pop_front();
      chk(xt, int'(data_o), xc);
      chk("R7", int'(ovr_o), xo);
    end else begin
      chk("R10", int'(data_o), 512);
      chk("R10", int'(ovr_o), 0);
    end
    chk("R8/R9", int'(valid_o), (run >= 4) ? 1 : 0);
    cyc++;
  endtask

  initial begin
    rst_n = 1'b0;
    coarse_i = 5'd3; fine_i = 6'd9;
    ovr_pos_i = 1'b1; ovr_neg_i = 1'b0; idle_i = 1'b0; flush_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R10", int'(data_o), 512);
      chk("R10", int'(ovr_o), 0);
      chk("R10", int'(valid_o), 0);
    end
    rst_n = 1'b1;
    // R1 R2 R3 R7: every coarse/fine pair with no flags, including exact
    // full-scale merges (31,47) and (0,16).
    for (int c = 0; c < 32; c++)
      for (int f = 0; f < 64; f++)
        step(c, f, 1'b0, 1'b0, 1'b0, 1'b1);
    // R4 R5 R6: all flag combinations across the coarse range.
    for (int i = 0; i < 1024; i++)
      step(i % 32, (i * 7) % 64, i[0], i[1], 1'b0, 1'b1);
    // R8 R9: idle gaps and flush pulses of varied spacing.
    for (int i = 0; i < 600; i++) begin
      bit idl, fl;
      int ph;
      ph  = i % 53;
      idl = (ph == 5) || (ph >= 20 && ph <= 22) || (i % 97 == 60);
      fl  = !((ph == 40) || (ph == 43) || (i % 89 == 11));
      step((i * 5) % 32, (i * 13) % 64, (i % 11) == 3, (i % 13) == 4, idl, fl);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: got no completion expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule